// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command front end of a byte-wide parallel NOR flash. It observes write cycles on a 16-bit address bus and an 8-bit data bus. Each cycle is framed by an active-low chip select and an active-low write strobe. The block recognises the key-prefixed command sequences and turns each complete sequence into a one-clock action pulse: program one byte, erase the whole array, lock the boot region, or enter or leave identification mode. The memory array and the timing of program and erase live outside this block, and they act on these pulses.

A write counts only when the chip is selected, the write strobe is low and the output enable is high. The strobe must also stay in that state for at least `FILT_N` clocks, so shorter pulses are dropped as noise. The boot-lock flag holds until reset. Once it is set, programs aimed at the bottom boot region are suppressed, and erase pulses tell the array to keep that region. While identification mode is active, reads return a manufacturer code, a device code and the lock status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle, `boot_locked` and `id_mode` are 0, and no action pulse is issued.
- R2: Four accepted writes AA@5555h, 55@2AAAh, A0@5555h, then D@A raise `prog_valid` for exactly one clock, with `prog_addr`=A and `prog_data`=D.
- R3: The six writes AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h raise `erase_valid` for exactly one clock. `erase_keep_boot` then equals the lock flag.
- R4: The same six-write pattern ending in 40 instead of 10 sets `boot_locked`, issues no erase, and the flag stays set until reset.
- R5: AA@5555h, 55@2AAAh, 90@5555h set `id_mode`. An identification read (select low, output enable low, write strobe high) returns `MFR_CODE` at address 0 and `DEV_CODE` at address 1, with `id_rd_valid` high.
- R6: `id_mode` clears either on the three-write form ending F0@5555h or on a single write of F0 to any address from idle.
- R7: While locked, a program whose target address is below `BOOT_BYTES` gives no pulse. A target at or above it is still programmed.
- R8: In identification mode, a read of address 0002h returns the lock flag on bit 0 and zeros on bits 7:1.
- R9: A write that breaks the expected sequence returns the decoder to idle, and that write has no effect.
- R10: A write with output enable low is not accepted.
- R11: A strobe pulse shorter than `FILT_N` clocks is discarded. A pulse of `FILT_N` clocks is accepted.
- R12: `prog_valid` and `erase_valid` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| prog_valid | output | 1 | One-clock byte program request |
| prog_addr | output | 16 | Program target address |
| prog_data | output | 8 | Byte to program |
| erase_valid | output | 1 | One-clock chip erase request |
| erase_keep_boot | output | 1 | Erase must spare the boot region |
| boot_locked | output | 1 | Sticky boot-lock flag |
| id_mode | output | 1 | Identification mode active |
| id_rd_valid | output | 1 | Identification read in progress |
| id_rdata | output | 8 | Identification read data |

## Verification
The bench builds the decoder with `FILT_N`=3 and keeps the default `BOOT_BYTES` of 8192. With a three-clock threshold, a rejected two-clock pulse and an accepted three-clock pulse each take only a few cycles. The 8192-byte boundary places the last protected address at 1FFFh and the first free address at 2000h, so the lock check is tested on both sides of its edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Sequence keys and opcodes
    localparam addr_t KEY_ADDR_A   = 16'h5555;
    localparam addr_t KEY_ADDR_B   = 16'h2AAA;
    localparam byte_t KEY_DATA_A   = 8'hAA;
    localparam byte_t KEY_DATA_B   = 8'h55;
    localparam byte_t OP_PROGRAM   = 8'hA0;
    localparam byte_t OP_EXTENDED  = 8'h80;
    localparam byte_t OP_ID_ENTER  = 8'h90;
    localparam byte_t OP_ID_LEAVE  = 8'hF0;
    localparam byte_t OP_ERASE_ALL = 8'h10;
    localparam byte_t OP_LOCK_BOOT = 8'h40;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG_ARM,
        SQ_EXT_PRE,
        SQ_EXT_KEY1,
        SQ_EXT_KEY2
    } seq_state_e;

    typedef struct packed {
        addr_t addr;
        byte_t data;
    } bus_write_t;

    typedef struct packed {
        logic prog;
        logic erase;
        logic lock_set;
        logic id_on;
        logic id_off;
    } seq_action_t;

    function automatic logic key_match(bus_write_t w, addr_t a, byte_t d);
        return (w.addr == a) && (w.data == d);
    endfunction

    function automatic logic in_boot(addr_t a, int unsigned limit);
        return 32'(a) < limit;
    endfunction

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter
    import flash_cmd_pkg::*;
#(
    parameter int FILT_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  addr_t      addr,
    input  byte_t      wdata,
    output logic       wr_commit,
    output bus_write_t wr_beat
);
    localparam int CNT_W = $clog2(FILT_N + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(FILT_N);

    logic             wr_act;
    logic [CNT_W-1:0] run_len;

    assign wr_act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            wr_commit <= 1'b0;
            wr_beat   <= '0;
        end else begin
            wr_commit <= !wr_act && (run_len == RUN_MAX);
            if (wr_act) begin
                if (run_len != RUN_MAX)
                    run_len <= run_len + 1'b1;
                if (run_len == '0)
                    wr_beat.addr <= addr;
                wr_beat.data <= wdata;
            end else begin
                run_len <= '0;
            end
        end
    end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_commit,
    input  bus_write_t  wr_beat,
    output seq_action_t act
);
    seq_state_e state, nxt;

    always_comb begin
        nxt = state;
        act = '0;
        if (wr_commit) begin
            case (state)
                SQ_IDLE: begin
                    if (key_match(wr_beat, KEY_ADDR_A, KEY_DATA_A))
                        nxt = SQ_KEY1;
                    else if (wr_beat.data == OP_ID_LEAVE)
                        act.id_off = 1'b1;
                end
                SQ_KEY1:
                    nxt = key_match(wr_beat, KEY_ADDR_B, KEY_DATA_B) ? SQ_KEY2 : SQ_IDLE;
                SQ_KEY2: begin
                    nxt = SQ_IDLE;
                    if (wr_beat.addr == KEY_ADDR_A) begin
                        case (wr_beat.data)
                            OP_PROGRAM:  nxt = SQ_PROG_ARM;
                            OP_EXTENDED: nxt = SQ_EXT_PRE;
                            OP_ID_ENTER: act.id_on = 1'b1;
                            OP_ID_LEAVE: act.id_off = 1'b1;
                            default:     nxt = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PROG_ARM: begin
                    nxt = SQ_IDLE;
                    act.prog = 1'b1;
                end
                SQ_EXT_PRE:
                    nxt = key_match(wr_beat, KEY_ADDR_A, KEY_DATA_A) ? SQ_EXT_KEY1 : SQ_IDLE;
                SQ_EXT_KEY1:
                    nxt = key_match(wr_beat, KEY_ADDR_B, KEY_DATA_B) ? SQ_EXT_KEY2 : SQ_IDLE;
                SQ_EXT_KEY2: begin
                    nxt = SQ_IDLE;
                    if (wr_beat.addr == KEY_ADDR_A) begin
                        if (wr_beat.data == OP_ERASE_ALL)
                            act.erase = 1'b1;
                        else if (wr_beat.data == OP_LOCK_BOOT)
                            act.lock_set = 1'b1;
                    end
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= SQ_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/flag_keeper.sv
module flag_keeper
    import flash_cmd_pkg::*;
#(
    parameter int unsigned BOOT_BYTES = 8192
) (
    input  logic        clk,
    input  logic        rst,
    input  seq_action_t act,
    input  bus_write_t  wr_beat,
    output logic        prog_valid,
    output addr_t       prog_addr,
    output byte_t       prog_data,
    output logic        erase_valid,
    output logic        erase_keep_boot,
    output logic        boot_locked,
    output logic        id_mode
);
    logic prog_blocked;

    assign prog_blocked = boot_locked && in_boot(wr_beat.addr, BOOT_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_valid      <= 1'b0;
            prog_addr       <= '0;
            prog_data       <= '0;
            erase_valid     <= 1'b0;
            erase_keep_boot <= 1'b0;
            boot_locked     <= 1'b0;
            id_mode         <= 1'b0;
        end else begin
            prog_valid  <= act.prog && !prog_blocked;
            erase_valid <= act.erase;
            if (act.prog) begin
                prog_addr <= wr_beat.addr;
                prog_data <= wr_beat.data;
            end
            if (act.erase)
                erase_keep_boot <= boot_locked;
            if (act.lock_set)
                boot_locked <= 1'b1;
            if (act.id_on)
                id_mode <= 1'b1;
            else if (act.id_off)
                id_mode <= 1'b0;
        end
    end
endmodule

// File: rtl/id_readout.sv
module id_readout
    import flash_cmd_pkg::*;
#(
    parameter byte_t MFR_CODE = 8'hC5,
    parameter byte_t DEV_CODE = 8'h3A
) (
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  we_n,
    input  addr_t addr,
    input  logic  id_mode,
    input  logic  boot_locked,
    output logic  id_rd_valid,
    output byte_t id_rdata
);
    always_comb begin
        id_rd_valid = id_mode && !ce_n && !oe_n && we_n;
        id_rdata    = '0;
        if (id_rd_valid) begin
            case (addr)
                16'h0000: id_rdata = MFR_CODE;
                16'h0001: id_rdata = DEV_CODE;
                16'h0002: id_rdata = {{(DATA_W-1){1'b0}}, boot_locked};
                default:  id_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          FILT_N     = 4,
    parameter int unsigned BOOT_BYTES = 8192,
    parameter logic [7:0]  MFR_CODE   = 8'hC5,
    parameter logic [7:0]  DEV_CODE   = 8'h3A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic        prog_valid,
    output logic [15:0] prog_addr,
    output logic [7:0]  prog_data,
    output logic        erase_valid,
    output logic        erase_keep_boot,
    output logic        boot_locked,
    output logic        id_mode,
    output logic        id_rd_valid,
    output logic [7:0]  id_rdata
);
    logic        wr_commit;
    bus_write_t  wr_beat;
    seq_action_t act;

    strobe_filter #(.FILT_N(FILT_N)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_commit (wr_commit),
        .wr_beat   (wr_beat)
    );

    cmd_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_commit (wr_commit),
        .wr_beat   (wr_beat),
        .act       (act)
    );

    flag_keeper #(.BOOT_BYTES(BOOT_BYTES)) u_flags (
        .clk             (clk),
        .rst             (rst),
        .act             (act),
        .wr_beat         (wr_beat),
        .prog_valid      (prog_valid),
        .prog_addr       (prog_addr),
        .prog_data       (prog_data),
        .erase_valid     (erase_valid),
        .erase_keep_boot (erase_keep_boot),
        .boot_locked     (boot_locked),
        .id_mode         (id_mode)
    );

    id_readout #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .addr        (addr),
        .id_mode     (id_mode),
        .boot_locked (boot_locked),
        .id_rd_valid (id_rd_valid),
        .id_rdata    (id_rdata)
    );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int unsigned BOOT_BYTES = 8192
) (
    input logic        clk,
    input logic        rst,
    input logic        prog_valid,
    input logic [15:0] prog_addr,
    input logic        erase_valid,
    input logic        boot_locked
);
    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        prog_valid |=> !prog_valid); // R2

    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        erase_valid |=> !erase_valid); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_locked |=> boot_locked); // R4

    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (rst)
        (prog_valid && boot_locked) |-> (32'(prog_addr) >= BOOT_BYTES)); // R7

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(prog_valid && erase_valid)); // R12
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.BOOT_BYTES(BOOT_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .prog_valid  (prog_valid),
    .prog_addr   (prog_addr),
    .erase_valid (erase_valid),
    .boot_locked (boot_locked)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int FILT = 3;
    localparam logic [7:0] MFR = 8'hC5;
    localparam logic [7:0] DEV = 8'h3A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        prog_valid, erase_valid, erase_keep_boot, boot_locked, id_mode, id_rd_valid;
    logic [15:0] prog_addr;
    logic [7:0]  prog_data, id_rdata;

    int checks = 0;
    int failures = 0;
    int prog_cnt = 0, erase_cnt = 0, both_cnt = 0;
    logic [15:0] last_pa = '0;
    logic [7:0]  last_pd = '0;
    logic        last_keep = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.FILT_N(FILT), .BOOT_BYTES(8192), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_valid(erase_valid), .erase_keep_boot(erase_keep_boot),
        .boot_locked(boot_locked), .id_mode(id_mode),
        .id_rd_valid(id_rd_valid), .id_rdata(id_rdata)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (prog_valid) begin
                prog_cnt++;
                last_pa = prog_addr;
                last_pd = prog_data;
            end
            if (erase_valid) begin
                erase_cnt++;
                last_keep = erase_keep_boot;
            end
            if (prog_valid && erase_valid) both_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d,
                          input int hold = FILT, input logic oe_lvl = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
        repeat (hold) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic unlock;
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
    endtask

    task automatic do_program(input logic [15:0] a, input logic [7:0] d);
        unlock;
        bus_wr(16'h5555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic do_extended(input logic [7:0] last);
        unlock;
        bus_wr(16'h5555, 8'h80);
        unlock;
        bus_wr(16'h5555, last);
    endtask

    task automatic id_read(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = id_rdata; v = id_rd_valid;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset;
        check("R1 locked", 32'(boot_locked), 0);
        check("R1 id_mode", 32'(id_mode), 0);
        check("R1 prog", 32'(prog_valid), 0);
        check("R1 erase", 32'(erase_valid), 0);
    endtask

    task automatic t_program;
        int p0 = prog_cnt;
        do_program(16'h3000, 8'h5A);
        check("R2 count", 32'(prog_cnt - p0), 1);
        check("R2 addr", 32'(last_pa), 32'h3000);
        check("R2 data", 32'(last_pd), 32'h5A);
        p0 = prog_cnt;
        do_program(16'h0100, 8'h33);
        check("R2 boot unlocked count", 32'(prog_cnt - p0), 1);
        check("R2 boot unlocked addr", 32'(last_pa), 32'h0100);
    endtask

    task automatic t_erase_unlocked;
        int e0 = erase_cnt;
        do_extended(8'h10);
        check("R3 count", 32'(erase_cnt - e0), 1);
        check("R3 keep", 32'(last_keep), 0);
    endtask

    task automatic t_glitch;
        int p0 = prog_cnt;
        bus_wr(16'h5555, 8'hAA, FILT - 1);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h4000, 8'h11);
        check("R11 short pulse dropped", 32'(prog_cnt - p0), 0);
        p0 = prog_cnt;
        unlock;
        bus_wr(16'h5555, 8'hA0, FILT);
        bus_wr(16'h4001, 8'h22, FILT);
        check("R11 threshold pulse taken", 32'(prog_cnt - p0), 1);
        check("R11 data", 32'(last_pd), 32'h22);
    endtask

    task automatic t_inhibit;
        int p0 = prog_cnt;
        bus_wr(16'h5555, 8'hAA, FILT, 1'b0);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h4100, 8'h44);
        check("R10 oe low blocks write", 32'(prog_cnt - p0), 0);
    endtask

    task automatic t_mismatch;
        int p0 = prog_cnt;
        int e0 = erase_cnt;
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h56);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h4200, 8'h66);
        check("R9 broken key no prog", 32'(prog_cnt - p0), 0);
        unlock;
        bus_wr(16'h5555, 8'h80);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAB, 8'h55);
        bus_wr(16'h5555, 8'h10);
        check("R9 broken erase", 32'(erase_cnt - e0), 0);
        do_program(16'h4300, 8'h77);
        check("R9 recovers", 32'(prog_cnt - p0), 1);
    endtask

    task automatic t_id_mode(input logic exp_lock);
        logic [7:0] d;
        logic v;
        unlock;
        bus_wr(16'h5555, 8'h90);
        check("R5 entered", 32'(id_mode), 1);
        id_read(16'h0000, d, v);
        check("R5 mfr", 32'(d), 32'(MFR));
        check("R5 valid", 32'(v), 1);
        id_read(16'h0001, d, v);
        check("R5 dev", 32'(d), 32'(DEV));
        id_read(16'h0002, d, v);
        check("R8 lock status", 32'(d), 32'(exp_lock));
        unlock;
        bus_wr(16'h5555, 8'hF0);
        check("R6 three-write exit", 32'(id_mode), 0);
        id_read(16'h0000, d, v);
        check("R6 no id read after exit", 32'(v), 0);
        unlock;
        bus_wr(16'h5555, 8'h90);
        check("R5 re-entered", 32'(id_mode), 1);
        bus_wr(16'h7123, 8'hF0);
        check("R6 single exit", 32'(id_mode), 0);
    endtask

    task automatic t_lockout;
        int e0 = erase_cnt;
        do_extended(8'h40);
        check("R4 lock set", 32'(boot_locked), 1);
        check("R4 no erase", 32'(erase_cnt - e0), 0);
        repeat (10) @(negedge clk);
        check("R4 sticky", 32'(boot_locked), 1);
    endtask

    task automatic t_locked_ops;
        int p0 = prog_cnt;
        int e0 = erase_cnt;
        do_program(16'h1FFF, 8'h01);
        check("R7 top of boot blocked", 32'(prog_cnt - p0), 0);
        do_program(16'h0000, 8'h02);
        check("R7 bottom of boot blocked", 32'(prog_cnt - p0), 0);
        do_program(16'h2000, 8'h03);
        check("R7 above boot allowed", 32'(prog_cnt - p0), 1);
        check("R7 addr", 32'(last_pa), 32'h2000);
        do_extended(8'h10);
        check("R3 locked erase count", 32'(erase_cnt - e0), 1);
        check("R3 keep boot", 32'(last_keep), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset;
        t_program;
        t_erase_unlocked;
        t_glitch;
        t_inhibit;
        t_mismatch;
        t_id_mode(1'b0);
        t_lockout;
        t_locked_ops;
        t_id_mode(1'b1);
        check("R12 no overlap", 32'(both_cnt), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule